// File: doc/BRIEF.md
# Periodic and One-Shot Comparator Channel

This block is one timer channel. Several copies are placed side by side, and all of them watch one shared free-running main counter. Each channel holds a compare value. When the counter steps onto that value while counting is enabled, the channel raises a single-cycle fire strobe. In one-shot mode the compare value stays where it was put. If that value is already behind the count, the strobe comes only after the counter wraps. In periodic mode the channel keeps a period, and after each match it moves the compare value forward by that period, wrapping modulo 2^CW.

Comparator writes behave differently in each mode. In one-shot mode a write goes straight into the compare value. In periodic mode a write sets the period. It loads the compare value as well only when a value-set flag has been armed by a configuration write. Every comparator write clears that flag. If counting is switched off while the count sits on the compare value and that match was never serviced by a counter step, the channel fires at the moment counting stops.

The counter itself, the register bus decode and interrupt delivery live outside this block. The counter advances by one per tick. `cnt_i` already shows the new value in the cycle where `cnt_tick_i` is high.

Top module: `tchan_cmp`

## Requirements
- R1: After reset the compare value is all ones, the period is 0, the value-set flag is 0, the mode is one-shot (`periodic_o`=0) and `fire_o` is low.
- R2: In one-shot mode a comparator write loads `cmp_o` with the written data one cycle later, and `period_o` stays 0.
- R3: In periodic mode a comparator write loads `period_o` with the data. `cmp_o` takes the data too only if the value-set flag was 1 before the write; otherwise `cmp_o` keeps its value.
- R4: Every comparator write leaves `valset_o` at 0 on the next cycle, in either mode. A configuration write without a comparator write sets `valset_o` to `cfg_valset_i`.
- R5: A configuration write with `cfg_periodic_i`=0 selects one-shot mode and forces `period_o` to 0 on the next cycle. With `cfg_periodic_i`=1 it selects periodic mode (`periodic_o`=1).
- R6: When `cnt_tick_i` and `cnt_run_i` are both high and `cnt_i` equals the compare value, `fire_o` is high for exactly the following cycle. Ticks that come back to back or spaced apart each give at most one strobe.
- R7: On a periodic match with no comparator write in the same cycle, the compare value becomes compare + period modulo 2^CW. A comparator write in that cycle takes priority over the advance.
- R8: In one-shot mode, once the counter has passed the compare value it does not fire again. A compare value behind the count fires only when the counter wraps around onto it.
- R9: When `cnt_run_i` falls while `cnt_i` equals the compare value and that value was never matched by a tick, `fire_o` pulses once in the next cycle.
- R10: Ticks while `cnt_run_i` is low produce no strobe and no advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cnt_i | input | CW | Shared main counter value |
| cnt_tick_i | input | 1 | Counter stepped onto `cnt_i` this cycle |
| cnt_run_i | input | 1 | Counting enabled |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_periodic_i | input | 1 | Mode for configuration write: 1 periodic, 0 one-shot |
| cfg_valset_i | input | 1 | Value-set flag for configuration write |
| cmp_wr_i | input | 1 | Comparator write strobe |
| cmp_wdata_i | input | CW | Comparator write data |
| fire_o | output | 1 | One-cycle match strobe |
| cmp_o | output | CW | Current compare value |
| period_o | output | CW | Current period |
| periodic_o | output | 1 | 1 when in periodic mode |
| valset_o | output | 1 | Value-set flag |

## Verification
The hardest case to reach is the stop-time flush of R9. It needs a compare value that equals the count without the counter ever having stepped onto it. The stimulus gets there by holding the counter still with counting enabled, writing the current count into the comparator, and then dropping the run input. The one-shot wrap case of R8 is reached by reloading the counter just below 2^32 and ticking it through zero. A behavioural reference model, compared every cycle, covers period advances across the wrap and ticks spaced several cycles apart.

// File: rtl/tchan_pkg.sv
package tchan_pkg;
   typedef enum logic {
      CH_ONESHOT  = 1'b0,
      CH_PERIODIC = 1'b1
   } ch_mode_e;
endpackage

// File: rtl/tchan_match.sv
module tchan_match #(
   parameter int CW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] cnt_i,
   input  logic          tick_i,
   input  logic          run_i,
   input  logic [CW-1:0] cmp_i,
   input  logic          cmp_wr_i,
   output logic          match_o,
   output logic          fire_o
);
   logic run_q, hit_q, fire_q, flush;

   assign match_o = tick_i && run_i && (cnt_i == cmp_i);
   assign flush   = run_q && !run_i && (cnt_i == cmp_i) && !hit_q;
   assign fire_o  = fire_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_q  <= 1'b0;
         hit_q  <= 1'b0;
         fire_q <= 1'b0;
      end else begin
         run_q  <= run_i;
         fire_q <= match_o || flush;
         if (cmp_wr_i)
            hit_q <= 1'b0;
         else if (tick_i && run_i)
            hit_q <= match_o;
      end
   end

   // R6
   fire_after_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && run_i && cnt_i == cmp_i) |=> fire_o);
   // R10
   idle_no_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !run_q) |=> !fire_o);
endmodule

// File: rtl/tchan_regs.sv
module tchan_regs
   import tchan_pkg::*;
#(
   parameter int CW          = 32,
   parameter bit PERIODIC_EN = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          cfg_wr_i,
   input  logic          cfg_periodic_i,
   input  logic          cfg_valset_i,
   input  logic          cmp_wr_i,
   input  logic [CW-1:0] cmp_wdata_i,
   input  logic          match_i,
   output logic [CW-1:0] cmp_o,
   output logic [CW-1:0] period_o,
   output logic          periodic_o,
   output logic          valset_o
);
   localparam logic [CW-1:0] CMP_RST = {CW{1'b1}};

   ch_mode_e      mode_q;
   logic [CW-1:0] period_q, cmp_q;
   logic          valset_q;

   generate
      if (PERIODIC_EN) begin : g_per
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               mode_q   <= CH_ONESHOT;
               period_q <= '0;
            end else begin
               if (cfg_wr_i)
                  mode_q <= cfg_periodic_i ? CH_PERIODIC : CH_ONESHOT;
               if (cfg_wr_i && !cfg_periodic_i)
                  period_q <= '0;
               else if (cmp_wr_i && mode_q == CH_PERIODIC)
                  period_q <= cmp_wdata_i;
            end
         end
      end else begin : g_oneshot
         logic unused_mode;
         assign unused_mode = cfg_periodic_i;
         assign mode_q      = CH_ONESHOT;
         assign period_q    = '0;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cmp_q    <= CMP_RST;
         valset_q <= 1'b0;
      end else begin
         if (cmp_wr_i)
            valset_q <= 1'b0;
         else if (cfg_wr_i)
            valset_q <= cfg_valset_i;
         if (cmp_wr_i) begin
            if (mode_q == CH_ONESHOT || valset_q)
               cmp_q <= cmp_wdata_i;
         end else if (match_i && mode_q == CH_PERIODIC) begin
            cmp_q <= cmp_q + period_q;
         end
      end
   end

   assign cmp_o      = cmp_q;
   assign period_o   = period_q;
   assign periodic_o = (mode_q == CH_PERIODIC);
   assign valset_o   = valset_q;

   // R4
   valset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_wr_i |=> !valset_o);
   // R5
   period_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_wr_i && !cfg_periodic_i) |=> (period_o == '0));
   // R2
   oneshot_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_wr_i && !periodic_o) |=> (cmp_o == $past(cmp_wdata_i)));
   // R3
   periodic_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_wr_i && periodic_o && !valset_o) |=> $stable(cmp_o));
endmodule

// File: rtl/tchan_cmp.sv
module tchan_cmp #(
   parameter int CW          = 32,
   parameter int NCHAN       = 8,
   parameter int CHAN_IDX    = 0,
   parameter bit PERIODIC_EN = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] cnt_i,
   input  logic          cnt_tick_i,
   input  logic          cnt_run_i,
   input  logic          cfg_wr_i,
   input  logic          cfg_periodic_i,
   input  logic          cfg_valset_i,
   input  logic          cmp_wr_i,
   input  logic [CW-1:0] cmp_wdata_i,
   output logic          fire_o,
   output logic [CW-1:0] cmp_o,
   output logic [CW-1:0] period_o,
   output logic          periodic_o,
   output logic          valset_o
);
   generate
      if (NCHAN < 3 || NCHAN > 32) begin : g_bad_nchan
         $error("tchan_cmp: NCHAN must lie in 3..32");
      end
      if (CHAN_IDX < 0 || CHAN_IDX >= NCHAN) begin : g_bad_idx
         $error("tchan_cmp: CHAN_IDX out of range");
      end
      if (CW < 2) begin : g_bad_cw
         $error("tchan_cmp: CW too small");
      end
   endgenerate

   logic match;

   tchan_match #(.CW(CW)) u_match (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cnt_i    (cnt_i),
      .tick_i   (cnt_tick_i),
      .run_i    (cnt_run_i),
      .cmp_i    (cmp_o),
      .cmp_wr_i (cmp_wr_i),
      .match_o  (match),
      .fire_o   (fire_o)
   );

   tchan_regs #(.CW(CW), .PERIODIC_EN(PERIODIC_EN)) u_regs (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .cfg_wr_i       (cfg_wr_i),
      .cfg_periodic_i (cfg_periodic_i),
      .cfg_valset_i   (cfg_valset_i),
      .cmp_wr_i       (cmp_wr_i),
      .cmp_wdata_i    (cmp_wdata_i),
      .match_i        (match),
      .cmp_o          (cmp_o),
      .period_o       (period_o),
      .periodic_o     (periodic_o),
      .valset_o       (valset_o)
   );

   // R7
   periodic_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_tick_i && cnt_run_i && cnt_i == cmp_o && periodic_o && !cmp_wr_i && !cfg_wr_i)
      |=> (cmp_o == $past(cmp_o) + $past(period_o)));
endmodule

// File: tb/tchan_cmp_test.sv
`timescale 1ns/1ps
module tchan_cmp_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cnt = '0;
   logic        tick = 1'b0, run = 1'b0;
   logic        cfg_we = 1'b0, cfg_per = 1'b0, cfg_vs = 1'b0;
   logic        cmp_we = 1'b0;
   logic [31:0] cmp_wd = '0;
   logic        fire_o, periodic_o, valset_o;
   logic [31:0] cmp_o, period_o;

   int errors = 0, checks = 0, fires = 0;

   always #2 clk = ~clk;

   tchan_cmp uut (
      .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_tick_i(tick), .cnt_run_i(run),
      .cfg_wr_i(cfg_we), .cfg_periodic_i(cfg_per), .cfg_valset_i(cfg_vs),
      .cmp_wr_i(cmp_we), .cmp_wdata_i(cmp_wd),
      .fire_o(fire_o), .cmp_o(cmp_o), .period_o(period_o),
      .periodic_o(periodic_o), .valset_o(valset_o)
   );

   // behavioural reference
   bit          m_per, m_vs, m_runq, m_hit, m_fire;
   logic [31:0] m_cmp, m_period;

   always @(posedge clk) begin
      bit hit_now, flush_now, old_per, old_vs;
      if (!rst_n) begin
         m_per = 0; m_vs = 0; m_runq = 0; m_hit = 0; m_fire = 0;
         m_cmp = 32'hFFFF_FFFF; m_period = 0;
      end else begin
         old_per = m_per; old_vs = m_vs;
         hit_now   = tick && run && (cnt == m_cmp);
         flush_now = m_runq && !run && (cnt == m_cmp) && !m_hit;
         m_fire = hit_now || flush_now;
         m_runq = run;
         if (cmp_we) m_hit = 0;
         else if (tick && run) m_hit = hit_now;
         if (cmp_we) begin
            if (!old_per || old_vs) m_cmp = cmp_wd;
         end else if (hit_now && old_per) begin
            m_cmp = m_cmp + m_period;
         end
         if (cfg_we && !cfg_per) m_period = 0;
         else if (cmp_we && old_per) m_period = cmp_wd;
         if (cfg_we) m_per = cfg_per;
         if (cmp_we) m_vs = 0;
         else if (cfg_we) m_vs = cfg_vs;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(fire_o == m_fire, "R6 fire strobe", {31'b0, fire_o}, {31'b0, m_fire});
         chk(cmp_o == m_cmp, "R7 compare value", cmp_o, m_cmp);
         chk(period_o == m_period, "R3 period", period_o, m_period);
         chk(valset_o == m_vs, "R4 value-set flag", {31'b0, valset_o}, {31'b0, m_vs});
         chk(periodic_o == m_per, "R5 mode", {31'b0, periodic_o}, {31'b0, m_per});
         if (fire_o) fires++;
      end
   end

   task automatic cyc();
      @(posedge clk); #1;
      cfg_we = 0; cmp_we = 0; tick = 0;
   endtask

   task automatic ticks(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         cnt = cnt + 1; tick = 1;
         cyc();
         for (int g = 0; g < gap; g++) cyc();
      end
   endtask

   task automatic wcmp(input logic [31:0] d);
      cmp_we = 1; cmp_wd = d; cyc();
   endtask

   task automatic wcfg(input bit p, input bit v);
      cfg_we = 1; cfg_per = p; cfg_vs = v; cyc();
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #800000;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      int f0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      cyc();
      chk(cmp_o == 32'hFFFF_FFFF, "R1 reset compare", cmp_o, 32'hFFFF_FFFF);
      chk(period_o == 0 && !valset_o && !periodic_o && !fire_o, "R1 reset state",
          {period_o[28:0], valset_o, periodic_o, fire_o}, 0);

      // one-shot
      run = 1; cnt = 10;
      wcmp(20);
      chk(cmp_o == 20 && period_o == 0, "R2 one-shot load", cmp_o, 20);
      f0 = fires;
      ticks(15, 0); cyc();
      chk(fires - f0 == 1, "R6 single one-shot strobe", fires - f0, 1);
      ticks(10, 0); cyc();
      chk(fires - f0 == 1, "R8 no refire after pass", fires - f0, 1);

      // compare in the past: wraps before firing
      wcmp(5);
      f0 = fires;
      ticks(20, 0); cyc();
      chk(fires == f0, "R8 past compare silent", fires - f0, 0);
      cnt = 32'hFFFF_FFF0;
      ticks(25, 0); cyc();
      chk(fires - f0 == 1, "R8 fire after wrap", fires - f0, 1);

      // ticks ignored while stopped
      run = 0; cyc(); cyc();
      wcmp(cnt + 3);
      f0 = fires;
      ticks(6, 0); cyc();
      chk(fires == f0, "R10 no strobe while stopped", fires - f0, 0);
      chk(cmp_o == cnt - 3, "R10 no advance while stopped", cmp_o, cnt - 3);

      // stop-time flush
      run = 1; cnt = 200; cyc();
      wcmp(200);
      f0 = fires;
      run = 0; cyc(); cyc();
      chk(fires - f0 == 1, "R9 flush at stop", fires - f0, 1);
      run = 1; cyc();

      // periodic with value-set
      wcfg(1, 1);
      chk(valset_o && periodic_o, "R4 value-set armed", {31'b0, valset_o}, 1);
      cnt = 35;
      wcmp(40);
      chk(cmp_o == 40 && period_o == 40, "R3 value-set load", cmp_o, 40);
      chk(!valset_o, "R4 cleared by write", {31'b0, valset_o}, 0);
      f0 = fires;
      ticks(50, 0); cyc();
      chk(fires - f0 == 2, "R7 two periodic strobes", fires - f0, 2);
      chk(cmp_o == 120, "R7 advanced compare", cmp_o, 120);
      wcmp(10);
      chk(period_o == 10 && cmp_o == 120, "R3 period-only write", period_o, 10);
      ticks(35, 2);
      chk(cmp_o == 130, "R7 advance with spaced ticks", cmp_o, 130);

      // periodic wrap
      wcfg(1, 1);
      wcmp(32'hFFFF_FFF8);
      wcmp(16);
      cnt = 32'hFFFF_FFF0;
      ticks(20, 0); cyc();
      chk(cmp_o == 32'h8, "R7 modulo advance", cmp_o, 32'h8);
      ticks(6, 0); cyc();
      chk(cmp_o == 32'h18, "R7 second advance after wrap", cmp_o, 32'h18);

      // leave periodic
      wcfg(0, 0);
      chk(period_o == 0 && !periodic_o, "R5 period forced to zero", period_o, 0);
      wcmp(77);
      chk(cmp_o == 77 && period_o == 0, "R2 one-shot write after leaving", cmp_o, 77);
      cyc(); cyc();
      finish_run();
   end
endmodule